// File: doc/BRIEF.md
# Debounced Discrete Input Monitor

This block watches a bank of asynchronous discrete input pins. Each pin is brought into the clock domain through a two-flop synchronizer. A per-channel filter then produces a clean level that changes only after the synchronized input has disagreed with it for a set number of clock cycles. Any change of a filtered level is recorded in a sticky per-channel activity flag.

The first channels are also counted. Every falling edge of the synchronized signal advances a counter for that channel, and the same edge sets the channel's activity flag. A pulse too short to pass the filter is therefore still recorded, but only if it contains a falling edge.

Software reads the block through a small byte register map. Through the same map it clears flags and counters with write-one-to-clear bytes.

Top module: `discrete_input_monitor`

## Requirements
- R1: After reset the filtered state is 0. The filtered state of a channel takes the synchronized input value only after that value has differed from it for DEB_CYCLES consecutive clock cycles. Shorter excursions leave it unchanged. It reads at address 0, bit n = channel n.
- R2: An activity bit (address 1, bit n = channel n) is set by every change of that channel's filtered state, rising or falling. It stays set until it is cleared.
- R3: On counted channels (0 to NUM_CNT-1), a synchronized falling edge also sets the activity bit, even when the filtered state never changes. A short glitch on an uncounted channel sets nothing.
- R4: A write to address 2 clears each activity bit whose written bit is 1 and leaves the bits written as 0 unchanged. Address 2 reads as zero.
- R5: Each counted channel's counter adds one on every synchronized falling edge. This includes a falling edge every second clock cycle. The counter wraps from all ones to zero.
- R6: A write to address 3 zeroes counter c when written bit c is 1 and leaves the other counters unchanged. The clear takes priority over an increment in the same cycle. Address 3 reads as zero.
- R7: When an activity set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R8: Counter c is read at addresses 4+4c to 7+4c, least significant byte first. Bytes above CNT_W read zero. Unmapped addresses read zero. After reset, all counters and activity bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NUM_CH | Asynchronous discrete inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |

## Verification
The bench builds the block with DEB_CYCLES = 6 and CNT_W = 8. The short filter window makes it cheap to hold a level just under and just over the threshold. The narrow counter lets a burst of a few hundred one-cycle pulses carry a counter through its wrap to zero. With these values the bench can also place a falling edge in exactly the cycle of a clearing write. That exercises both same-cycle priority rules at the register ports.

// File: rtl/dio_mon_pkg.sv
package dio_mon_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATE     = 4'd0,
        REG_LATCH     = 4'd1,
        REG_LATCH_CLR = 4'd2,
        REG_CNT_CLR   = 4'd3
    } reg_addr_e;

    typedef struct packed {
        logic [BYTE_W-1:0] latch_clr;
        logic [BYTE_W-1:0] cnt_clr;
    } clr_req_t;

    function automatic clr_req_t decode_write(input logic en,
                                              input logic [ADDR_W-1:0] addr,
                                              input logic [BYTE_W-1:0] data);
        clr_req_t r;
        r.latch_clr = (en && addr == REG_LATCH_CLR) ? data : '0;
        r.cnt_clr   = (en && addr == REG_CNT_CLR)   ? data : '0;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] word_byte(input logic [31:0] v,
                                                    input logic [1:0] k);
        return v[k*8 +: 8];
    endfunction

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dio_debounce.sv
module dio_debounce #(
    parameter int unsigned W          = 8,
    parameter int unsigned DEB_CYCLES = 500000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] state,
    output logic [W-1:0] chg
);
    localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES - 1);

    for (genvar i = 0; i < W; i++) begin : g_ch
        logic [CW-1:0] run;

        always_ff @(posedge clk) begin
            if (rst) begin
                run      <= '0;
                state[i] <= 1'b0;
                chg[i]   <= 1'b0;
            end else begin
                chg[i] <= 1'b0;
                if (din[i] != state[i]) begin
                    if (run == LIMIT) begin
                        state[i] <= din[i];
                        chg[i]   <= 1'b1;
                        run      <= '0;
                    end else begin
                        run <= run + 1'b1;
                    end
                end else begin
                    run <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/dio_edge_counter.sv
module dio_edge_counter #(
    parameter int unsigned N     = 2,
    parameter int unsigned CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N-1:0]              din,
    input  logic [N-1:0]              clr,
    output logic [N-1:0]              fall,
    output logic [N-1:0][CNT_W-1:0]   cnt
);
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= din;
    end

    assign fall = prev & ~din;

    for (genvar c = 0; c < N; c++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clr[c]) cnt[c] <= '0;
            else if (fall[c])  cnt[c] <= cnt[c] + 1'b1;
        end
    end
endmodule

// File: rtl/discrete_input_monitor.sv
module discrete_input_monitor
    import dio_mon_pkg::*;
#(
    parameter int unsigned NUM_CH     = 8,
    parameter int unsigned NUM_CNT    = 2,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned DEB_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_raw,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [NUM_CH-1:0]              pin_sync;
    logic [NUM_CH-1:0]              deb_state;
    logic [NUM_CH-1:0]              deb_chg;
    logic [NUM_CNT-1:0]             fall_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
    logic [NUM_CH-1:0]              latch_q;
    logic [NUM_CH-1:0]              set_mask;
    logic [NUM_CH-1:0]              clr_mask;
    logic [NUM_CNT-1:0]             cnt_clr;
    clr_req_t                       req;

    dio_sync #(.W(NUM_CH)) u_sync (
        .clk(clk), .rst(rst), .d(pin_raw), .q(pin_sync)
    );

    dio_debounce #(.W(NUM_CH), .DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .rst(rst), .din(pin_sync), .state(deb_state), .chg(deb_chg)
    );

    dio_edge_counter #(.N(NUM_CNT), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .din(pin_sync[NUM_CNT-1:0]), .clr(cnt_clr),
        .fall(fall_vec), .cnt(cnt_q)
    );

    assign req      = decode_write(wr_en, wr_addr, wr_data);
    assign clr_mask = req.latch_clr[NUM_CH-1:0];
    assign cnt_clr  = req.cnt_clr[NUM_CNT-1:0];

    always_comb begin
        set_mask = deb_chg;
        set_mask[NUM_CNT-1:0] = deb_chg[NUM_CNT-1:0] | fall_vec;
    end

    // set is applied after clear so simultaneous activity is never lost
    always_ff @(posedge clk) begin
        if (rst) latch_q <= '0;
        else     latch_q <= (latch_q & ~clr_mask) | set_mask;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_STATE: rd_data = BYTE_W'(deb_state);
            REG_LATCH: rd_data = BYTE_W'(latch_q);
            default:   rd_data = '0;
        endcase
        for (int c = 0; c < NUM_CNT; c++) begin
            if (rd_addr[ADDR_W-1:2] == (ADDR_W-2)'(c + 1))
                rd_data = word_byte(32'(cnt_q[c]), rd_addr[1:0]);
        end
    end
endmodule

// File: rtl/dio_mon_checker.sv
module dio_mon_checker
    import dio_mon_pkg::*;
#(
    parameter int unsigned NUM_CH  = 8,
    parameter int unsigned NUM_CNT = 2,
    parameter int unsigned CNT_W   = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_CH-1:0]         latch_q,
    input logic [NUM_CH-1:0]         deb_chg,
    input logic [NUM_CH-1:0]         set_mask,
    input logic [NUM_CH-1:0]         clr_mask,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q,
    input logic [ADDR_W-1:0]         rd_addr,
    input logic [BYTE_W-1:0]         rd_data
);
    // R2: a bit that was set and not cleared stays set
    p_latch_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~latch_q & $past(latch_q & ~clr_mask)) == '0));

    // R2: a filtered change appears in the activity byte one cycle later
    p_chg_latched_r2: assert property (@(posedge clk) disable iff (rst)
        (|deb_chg) |=> ((latch_q & $past(deb_chg)) == $past(deb_chg)));

    // R7: set beats clear on the same bit
    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (|(set_mask & clr_mask)) |=> ((latch_q & $past(set_mask)) == $past(set_mask)));

    // R4 and R6: the clear bytes read as zero
    p_clear_regs_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == REG_LATCH_CLR || rd_addr == REG_CNT_CLR) |-> (rd_data == '0));

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt_chk
        // R5: counters only hold, step by one or go to zero
        p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (cnt_q[c] == $past(cnt_q[c]) ||
                      cnt_q[c] == CNT_W'($past(cnt_q[c]) + 1'b1) ||
                      cnt_q[c] == '0));

        // R3: a counted edge always marks activity
        p_count_marks_activity_r3: assert property (@(posedge clk) disable iff (rst)
            (cnt_q[c] != '0 && cnt_q[c] == CNT_W'($past(cnt_q[c]) + 1'b1)) |-> latch_q[c]);
    end
endmodule

bind discrete_input_monitor dio_mon_checker #(
    .NUM_CH(NUM_CH), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .latch_q(latch_q), .deb_chg(deb_chg),
    .set_mask(set_mask), .clr_mask(clr_mask), .cnt_q(cnt_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/discrete_input_monitor_bench.sv
module discrete_input_monitor_bench;
    localparam int unsigned DEB  = 6;
    localparam int unsigned CW   = 8;
    localparam int unsigned NCNT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_raw = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0] exp_state = '0;
    logic [7:0] exp_latch = '0;
    int         exp_cnt [NCNT];

    always #2 clk = ~clk;

    discrete_input_monitor #(.NUM_CH(8), .NUM_CNT(NCNT), .CNT_W(CW), .DEB_CYCLES(DEB))
        u_discrete_input_monitor (
        .clk(clk), .rst(rst), .pin_raw(pin_raw), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [1:0] falls(input logic [7:0] o, input logic [7:0] n);
        return o[1:0] & ~n[1:0];
    endfunction

    task automatic check_all(input string tag);
        logic [7:0] d;
        rd(4'd0, d); check({tag, " R1 state"}, d, exp_state);
        rd(4'd1, d); check({tag, " R2 latch"}, d, exp_latch);
        for (int c = 0; c < NCNT; c++) begin
            rd(4'(4 + 4*c), d); check({tag, " R5 count"}, d, exp_cnt[c] & 8'hFF);
        end
    endtask

    task automatic apply_level(input logic [7:0] v);
        logic [1:0] f;
        f = falls(exp_state, v);
        @(negedge clk);
        pin_raw = v;
        repeat (DEB + 6) @(negedge clk);
        exp_latch |= exp_state ^ v;
        for (int c = 0; c < NCNT; c++) if (f[c]) exp_cnt[c]++;
        exp_state = v;
    endtask

    // excursion shorter than the filter window; one falling edge per counted channel
    task automatic glitch(input logic [7:0] m, input int len);
        @(negedge clk);
        pin_raw = exp_state ^ m;
        repeat (len) @(negedge clk);
        pin_raw = exp_state;
        repeat (8) @(negedge clk);
        for (int c = 0; c < NCNT; c++) if (m[c]) begin
            exp_cnt[c]++;
            exp_latch[c] = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        void'($urandom(32'd7051));
        for (int c = 0; c < NCNT; c++) exp_cnt[c] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R8 reset state and map
        check_all("reset R8");
        rd(4'd2, d);  check("R4 latch clear reads zero", d, 0);
        rd(4'd3, d);  check("R6 counter clear reads zero", d, 0);
        rd(4'd15, d); check("R8 unmapped", d, 0);
        rd(4'd5, d);  check("R8 counter upper byte", d, 0);

        // R1: not yet visible just inside the window
        @(negedge clk);
        pin_raw = 8'hFF;
        repeat (DEB - 1) @(negedge clk);
        rd(4'd0, d); check("R1 before window", d, 8'h00);
        repeat (DEB + 4) @(negedge clk);
        exp_state = 8'hFF; exp_latch = 8'hFF;
        check_all("rise all R2");

        // R4 partial clears
        wr(4'd2, 8'h0F); exp_latch = 8'hF0;
        rd(4'd1, d); check("R4 partial clear", d, exp_latch);
        wr(4'd2, 8'hF0); exp_latch = 8'h00;
        rd(4'd1, d); check("R4 rest clear", d, exp_latch);

        // R3 low glitch on counted ch0 and uncounted ch2
        glitch(8'h05, 2);
        check_all("low glitch R3");

        apply_level(8'h00);
        check_all("fall all R2 R5");

        // R3 high glitch from low on ch1 ends in a falling edge
        wr(4'd2, 8'hFF); exp_latch = 8'h00;
        glitch(8'h42, 2);
        check_all("high glitch R3");

        // R7: falling edge seen in same cycle as a clearing write
        wr(4'd2, 8'hFF); exp_latch = 8'h00;
        @(negedge clk); pin_raw[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); pin_raw[0] = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'hFF;
        @(negedge clk); wr_en = 1'b0;
        exp_latch[0] = 1'b1; exp_cnt[0]++;
        repeat (4) @(negedge clk);
        check_all("R7 set beats clear");

        // R6: counter clear coinciding with an increment
        @(negedge clk); pin_raw[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); pin_raw[0] = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = 4'd3; wr_data = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        exp_cnt[0] = 0;
        repeat (4) @(negedge clk);
        check_all("R6 clear beats increment");

        // R6 selective counter clear
        glitch(8'h03, 2);
        wr(4'd3, 8'h02); exp_cnt[1] = 0;
        check_all("R6 selective");

        // R5 fastest rate and wrap on ch1
        for (int i = 0; i < 256 + 5; i++) begin
            @(negedge clk); pin_raw[1] = 1'b1;
            @(negedge clk); pin_raw[1] = 1'b0;
        end
        repeat (8) @(negedge clk);
        exp_cnt[1] = 5; exp_latch[1] = 1'b1;
        check_all("R5 wrap");

        // random levels and clears
        for (int it = 0; it < 24; it++) begin
            v = 8'($urandom);
            apply_level(v);
            if ($urandom % 2 == 1) begin
                d = 8'($urandom);
                wr(4'd2, d); exp_latch &= ~d;
            end
            if ($urandom % 4 == 0) begin
                d = 8'($urandom);
                wr(4'd3, d);
                for (int c = 0; c < NCNT; c++) if (d[c]) exp_cnt[c] = 0;
            end
            check_all("random R1 R2 R4 R5 R6");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule